// File: doc/BRIEF.md
# Sixteen-Pin Register-Mapped GPIO Expander

This block turns a small byte-wide register interface into control of sixteen pads, grouped as two ports of eight. Pin n belongs to port n>>3 and sits at bit n mod 8 of that port's registers. Each pin can be an input or an output, can drive a programmed level, and can hand its pad over to an external alternate-function source. The pad level of every pin is sampled through a synchronizer and read back at any time.

A host writes configuration bytes over the address / write-data / write-strobe interface and reads state through the read strobe. The read byte is registered. Port 0 can be switched between open-drain and push-pull drive by a global control bit. Port 1 always drives push-pull. A fixed identification byte tells the host which block it is talking to. Writing zero to a reset address puts every register back to its power-on value without touching the reset pin.

Top module: `gpio_expander16`

## Requirements
- R1: After reset the direction registers (0x04, 0x05), mode registers (0x12, 0x13) and interrupt-disable registers (0x06, 0x07) read 0xFF, the output-level registers (0x02, 0x03) and global control (0x11) read 0x00, and every pad_oe bit is 0.
- R2: A byte written to an output-level, direction, mode or interrupt-disable register reads back unchanged. A GPIO-mode pin whose direction bit is 0 and that drives push-pull has pad_oe = 1 and pad_out equal to its output-level bit. This is visible in the cycle after the write.
- R3: For a GPIO-mode pin, a direction bit of 1 makes it an input with pad_oe = 0, and a direction bit of 0 makes it an output.
- R4: Input registers 0x00 (pins 0..7) and 0x01 (pins 8..15) return the pad value SYNC_STAGES clock edges after it is applied, whatever the pin direction. Writes to them have no effect.
- R5: When global control bit 4 is 0, a port-0 GPIO output drives pad_out = 0 and has pad_oe equal to the inverse of its output level. When bit 4 is 1, a port-0 GPIO output drives push-pull. Port 1 pins drive push-pull whatever the value of bit 4.
- R6: Address 0x10 reads 0x23, and writes to it have no effect.
- R7: Every address other than 0x00–0x07, 0x10–0x13 and 0x7F reads 0x00 and ignores writes. Address 0x7F also reads 0x00.
- R8: Writing 0x00 to address 0x7F returns every register to its R1 value in the following cycle. A non-zero write to 0x7F has no effect.
- R9: A pin whose mode bit is 0 has pad_oe = 1 and pad_out = alt_src for that pin, whatever its direction bit.
- R10: Global control keeps only bit 4 and bits 1:0. Its other bits read 0.
- R11: rd_data takes the addressed value in the cycle after rd_en is high, and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| alt_src | input | 16 | Per-pin alternate-function output values |
| pad_oe | output | 16 | Pad output enables |
| pad_out | output | 16 | Pad output values |

## Verification
The situation that is hardest to reach from the ports is an open-drain port-0 pin changing level while port 1 is set up the same way. To show that the drive-style bit acts on port 0 alone, the stimulus sets both ports to outputs with mixed levels. It then checks the enables of both ports with the bit cleared, and again with it set. Soft reset is exercised only after several registers hold values other than their defaults, so that the restore can be seen. A non-zero write to the reset address is placed before it to show that such a write changes nothing.

// File: rtl/gx_pkg.sv
package gx_pkg;
   localparam int BYTE_W = 8;
   localparam logic [6:0] A_IN0   = 7'h00;
   localparam logic [6:0] A_LVL0  = 7'h02;
   localparam logic [6:0] A_DIR0  = 7'h04;
   localparam logic [6:0] A_IDIS0 = 7'h06;
   localparam logic [6:0] A_ID    = 7'h10;
   localparam logic [6:0] A_GCTL  = 7'h11;
   localparam logic [6:0] A_MODE0 = 7'h12;
   localparam logic [6:0] A_SRST  = 7'h7F;
   localparam int GCTL_PP_BIT = 4;
   localparam logic [7:0] GCTL_KEEP = 8'h13;
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gx_regfile.sv
module gx_regfile
   import gx_pkg::*;
#(
   parameter int         ADDR_W  = 8,
   parameter logic [7:0] CHIP_ID = 8'h23,
   parameter int         PORTS   = 2,
   localparam int        PINS    = PORTS * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [7:0]        wdata,
   input  logic              rd,
   output logic [7:0]        rdata,
   input  logic [PINS-1:0]   in_sync,
   output logic [PINS-1:0]   lvl,
   output logic [PINS-1:0]   dir,
   output logic [PINS-1:0]   mode,
   output logic [PINS-1:0]   idis,
   output logic [7:0]        gctl
);
   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("gx_regfile: ADDR_W must reach address 0x7F");
      end
      if (PORTS != 2) begin : g_bad_ports
         $error("gx_regfile: the address map holds exactly two ports");
      end
   endgenerate

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [6:0] base);
      return a == ADDR_W'(base);
   endfunction

   logic soft_rst;
   assign soft_rst = wr && hit(addr, A_SRST) && (wdata == 8'h00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl  <= '0;
         dir  <= '1;
         mode <= '1;
         idis <= '1;
         gctl <= '0;
      end else if (soft_rst) begin
         lvl  <= '0;
         dir  <= '1;
         mode <= '1;
         idis <= '1;
         gctl <= '0;
      end else if (wr) begin
         for (int p = 0; p < PORTS; p++) begin
            if (hit(addr, A_LVL0 + 7'(p)))  lvl[p*BYTE_W +: BYTE_W]  <= wdata;
            if (hit(addr, A_DIR0 + 7'(p)))  dir[p*BYTE_W +: BYTE_W]  <= wdata;
            if (hit(addr, A_IDIS0 + 7'(p))) idis[p*BYTE_W +: BYTE_W] <= wdata;
            if (hit(addr, A_MODE0 + 7'(p))) mode[p*BYTE_W +: BYTE_W] <= wdata;
         end
         if (hit(addr, A_GCTL)) gctl <= wdata & GCTL_KEEP;
      end
   end

   logic [7:0] rd_mux;
   always_comb begin
      rd_mux = 8'h00;
      for (int p = 0; p < PORTS; p++) begin
         if (hit(addr, A_IN0 + 7'(p)))   rd_mux = in_sync[p*BYTE_W +: BYTE_W];
         if (hit(addr, A_LVL0 + 7'(p)))  rd_mux = lvl[p*BYTE_W +: BYTE_W];
         if (hit(addr, A_DIR0 + 7'(p)))  rd_mux = dir[p*BYTE_W +: BYTE_W];
         if (hit(addr, A_IDIS0 + 7'(p))) rd_mux = idis[p*BYTE_W +: BYTE_W];
         if (hit(addr, A_MODE0 + 7'(p))) rd_mux = mode[p*BYTE_W +: BYTE_W];
      end
      if (hit(addr, A_ID))   rd_mux = CHIP_ID;
      if (hit(addr, A_GCTL)) rd_mux = gctl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= 8'h00;
      else if (rd) rdata <= rd_mux;
   end

   logic unimpl;
   assign unimpl = (addr >= ADDR_W'(8'h08) && addr <= ADDR_W'(8'h0F)) ||
                   (addr >= ADDR_W'(8'h14));

   assert_chip_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit(addr, A_ID)) |=> (rdata == CHIP_ID));

   assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && unimpl) |=> (rdata == 8'h00));

   assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (dir == '1 && mode == '1 && idis == '1 && lvl == '0 && gctl == 8'h00));

   assert_gctl_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit(addr, A_GCTL)) |=> (rdata[7:5] == 3'b000 && rdata[3:2] == 2'b00));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));
endmodule

// File: rtl/gx_pad_drive.sv
module gx_pad_drive #(
   parameter int PINS    = 16,
   parameter int OD_PINS = 8
) (
   input  logic [PINS-1:0] mode,
   input  logic [PINS-1:0] dir,
   input  logic [PINS-1:0] lvl,
   input  logic [PINS-1:0] alt_src,
   input  logic            pp_sel,
   output logic [PINS-1:0] pad_oe,
   output logic [PINS-1:0] pad_out
);
   generate
      if (OD_PINS > PINS) begin : g_bad
         $error("gx_pad_drive: OD_PINS exceeds PINS");
      end
      for (genvar n = 0; n < PINS; n++) begin : g_pin
         if (n < OD_PINS) begin : g_od
            always_comb begin
               if (!mode[n]) begin
                  pad_oe[n]  = 1'b1;
                  pad_out[n] = alt_src[n];
               end else begin
                  pad_oe[n]  = !dir[n] && (pp_sel || !lvl[n]);
                  pad_out[n] = pp_sel && lvl[n];
               end
            end
         end else begin : g_pp
            always_comb begin
               if (!mode[n]) begin
                  pad_oe[n]  = 1'b1;
                  pad_out[n] = alt_src[n];
               end else begin
                  pad_oe[n]  = !dir[n];
                  pad_out[n] = lvl[n];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_expander16.sv
module gpio_expander16
   import gx_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] CHIP_ID     = 8'h23,
   localparam int        PORTS       = 2,
   localparam int        PINS        = PORTS * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_rd,
   output logic [7:0]        reg_rdata,
   input  logic [15:0]       pad_in,
   input  logic [15:0]       alt_src,
   output logic [15:0]       pad_oe,
   output logic [15:0]       pad_out
);
   logic [PINS-1:0] in_sync, lvl, dir, mode, idis;
   logic [7:0]      gctl;

   gx_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
   );

   gx_regfile #(.ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID), .PORTS(PORTS)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
      .rd(reg_rd), .rdata(reg_rdata), .in_sync(in_sync), .lvl(lvl), .dir(dir),
      .mode(mode), .idis(idis), .gctl(gctl)
   );

   gx_pad_drive #(.PINS(PINS), .OD_PINS(BYTE_W)) u_drive (
      .mode(mode), .dir(dir), .lvl(lvl), .alt_src(alt_src),
      .pp_sel(gctl[GCTL_PP_BIT]), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   generate
      for (genvar n = 0; n < PINS; n++) begin : g_chk
         assert_alt_takes_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !mode[n] |-> (pad_oe[n] && pad_out[n] == alt_src[n]));
         assert_input_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[n] && dir[n]) |-> !pad_oe[n]);
         if (n < BYTE_W) begin : g_od_chk
            assert_od_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (mode[n] && !dir[n] && !gctl[GCTL_PP_BIT] && lvl[n]) |-> (!pad_oe[n] && !pad_out[n]));
         end else begin : g_pp_chk
            assert_port1_pp_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (mode[n] && !dir[n]) |-> (pad_oe[n] && pad_out[n] == lvl[n]));
         end
      end
   endgenerate
endmodule

// File: tb/sim_gpio_expander16.sv
module sim_gpio_expander16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] alt_src = '0;
   logic [15:0] pad_oe, pad_out;

   int n_checks = 0;
   int n_fail = 0;

   gpio_expander16 u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .alt_src(alt_src), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   always #4 clk = ~clk;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic t_reset_defaults;
      logic [7:0] v;
      check("R1 pad_oe", pad_oe, 16'h0000);
      rd_reg(8'h04, v); check("R1 dir0", {8'h0, v}, 16'h00FF);
      rd_reg(8'h05, v); check("R1 dir1", {8'h0, v}, 16'h00FF);
      rd_reg(8'h12, v); check("R1 mode0", {8'h0, v}, 16'h00FF);
      rd_reg(8'h13, v); check("R1 mode1", {8'h0, v}, 16'h00FF);
      rd_reg(8'h06, v); check("R1 idis0", {8'h0, v}, 16'h00FF);
      rd_reg(8'h07, v); check("R1 idis1", {8'h0, v}, 16'h00FF);
      rd_reg(8'h02, v); check("R1 lvl0", {8'h0, v}, 16'h0000);
      rd_reg(8'h03, v); check("R1 lvl1", {8'h0, v}, 16'h0000);
      rd_reg(8'h11, v); check("R1 gctl", {8'h0, v}, 16'h0000);
   endtask

   task automatic t_push_pull_outputs;
      logic [7:0] v;
      wr_reg(8'h11, 8'h10);
      wr_reg(8'h03, 8'hC3);
      wr_reg(8'h05, 8'h00);
      check("R2 port1 oe", pad_oe, 16'hFF00);
      check("R2 port1 out", pad_out, 16'hC300);
      rd_reg(8'h03, v); check("R2 lvl1 readback", {8'h0, v}, 16'h00C3);
      wr_reg(8'h07, 8'h5A);
      rd_reg(8'h07, v); check("R2 idis1 readback", {8'h0, v}, 16'h005A);
      wr_reg(8'h05, 8'hF0);
      check("R3 upper half input", pad_oe, 16'h0F00);
   endtask

   task automatic t_input_sampling;
      logic [7:0] v;
      wr_reg(8'h04, 8'h00);
      @(negedge clk);
      pad_in = 16'hA55A;
      repeat (3) @(negedge clk);
      rd_reg(8'h00, v); check("R4 in0 with outputs", {8'h0, v}, 16'h005A);
      rd_reg(8'h01, v); check("R4 in1", {8'h0, v}, 16'h00A5);
      wr_reg(8'h01, 8'h00);
      rd_reg(8'h01, v); check("R4 in1 write ignored", {8'h0, v}, 16'h00A5);
   endtask

   task automatic t_open_drain;
      wr_reg(8'h11, 8'h00);
      wr_reg(8'h02, 8'h0F);
      wr_reg(8'h04, 8'h00);
      wr_reg(8'h03, 8'h0F);
      wr_reg(8'h05, 8'h00);
      check("R5 od oe", pad_oe, 16'hFFF0);
      check("R5 od out", pad_out, 16'h0F00);
      wr_reg(8'h11, 8'h10);
      check("R5 pp oe", pad_oe, 16'hFFFF);
      check("R5 pp out", pad_out, 16'h0F0F);
   endtask

   task automatic t_id_and_holes;
      logic [7:0] v;
      wr_reg(8'h10, 8'h77);
      rd_reg(8'h10, v); check("R6 id", {8'h0, v}, 16'h0023);
      wr_reg(8'h09, 8'hAA);
      rd_reg(8'h09, v); check("R7 hole 0x09", {8'h0, v}, 16'h0000);
      wr_reg(8'h40, 8'h55);
      rd_reg(8'h40, v); check("R7 hole 0x40", {8'h0, v}, 16'h0000);
      rd_reg(8'h7F, v); check("R7 reset addr reads 0", {8'h0, v}, 16'h0000);
      wr_reg(8'h11, 8'hFF);
      rd_reg(8'h11, v); check("R10 gctl mask", {8'h0, v}, 16'h0013);
   endtask

   task automatic t_alt_mode;
      wr_reg(8'h04, 8'hFF);
      alt_src = 16'h0001;
      wr_reg(8'h12, 8'hFC);
      check("R9 alt oe", pad_oe & 16'h0003, 16'h0003);
      check("R9 alt out", pad_out & 16'h0003, 16'h0001);
   endtask

   task automatic t_read_hold;
      logic [7:0] v;
      rd_reg(8'h10, v);
      wr_reg(8'h02, 8'h99);
      repeat (3) @(negedge clk);
      check("R11 rdata held", {8'h0, reg_rdata}, 16'h0023);
   endtask

   task automatic t_soft_reset;
      logic [7:0] v;
      wr_reg(8'h7F, 8'h01);
      rd_reg(8'h12, v); check("R8 nonzero write ignored", {8'h0, v}, 16'h00FC);
      wr_reg(8'h7F, 8'h00);
      check("R8 pads released", pad_oe, 16'h0000);
      rd_reg(8'h12, v); check("R8 mode0", {8'h0, v}, 16'h00FF);
      rd_reg(8'h02, v); check("R8 lvl0", {8'h0, v}, 16'h0000);
      rd_reg(8'h07, v); check("R8 idis1", {8'h0, v}, 16'h00FF);
      rd_reg(8'h11, v); check("R8 gctl", {8'h0, v}, 16'h0000);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_defaults();
      t_push_pull_outputs();
      t_input_sampling();
      t_open_drain();
      t_id_and_holes();
      t_alt_mode();
      t_read_hold();
      t_soft_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule